// File: doc/BRIEF.md
# Single-Cell Linear Charger Sequencer

This block is the digital supervisor of a linear charger for one lithium cell. It takes comparator flags that the analog side has already resolved (battery under the full-rate threshold, battery at the termination voltage, charge current under the end-of-charge level, battery under the restart level, temperature inside the allowed window), the presence of an adapter and of a USB supply, a charge-enable bit, a 1 ms tick and two configuration fields. From these it walks a cell through its phases: trickle pre-charge, constant current, constant voltage, a timed top-off, and completion.

The outputs are a regulation-mode code and a current-target code for the analog loop. A 3-bit status code reports the phase. A one-cycle interrupt pulse fires when the safety timer runs out. Two LED drives give 1 Hz blink patterns. The block also passes on the restart threshold code and the end-of-charge reference code that the comparators need. Every duration is counted in ticks, and a parameter (ticks per minute) shortens them for simulation.

The safety timer keeps one running count over all charging phases. Pre-charge is cut at 60 minutes of that count, and the whole charge at 600 minutes. Time spent in pre-charge therefore comes out of the overall allowance.

Top module: `lichg_seq`

## Requirements
- R1: After reset, status is 000, mode is 00, current target is 00, both LEDs are off and the interrupt is low.
- R2: With a source present, enable set and temperature in window, the sequencer leaves off for pre-charge (status 001, mode 01) when the battery is under the full-rate threshold, and for constant current (status 010, mode 10) otherwise. Pre-charge moves on to constant current once the flag clears.
- R3: The current target is 01 (10% of the programmed current) in pre-charge while the adapter is present, even when USB is also present. It is 10 (fixed 50 mA) in pre-charge on USB alone, 11 (full programmed current) in constant current, constant voltage and top-off, and 00 in every other state.
- R4: Constant current moves to constant voltage (status 011, mode 11) when the termination flag is set. Constant voltage moves to top-off (status 111, mode 11) when the end-of-charge flag is set. The end-of-charge reference output is 01 (5%) for config 0 and 10 (10%) for config 1 in constant voltage only, and 00 elsewhere.
- R5: Top-off lasts exactly 21 minutes of ticks, after which status is 101 (complete), with mode 00 and current target 00. Clearing enable while complete leaves the status at 101.
- R6: From complete, with enable set and the restart flag set, charging resumes in constant current and the safety count restarts from zero. The restart-level output is 00 (3.9 V), 01 (4.0 V) or 10 (4.2 V) for termination codes 00, 01 and 10. Termination code 11 maps to 00.
- R7: After 60 minutes of ticks in pre-charge, the status becomes 110 and the interrupt is high for exactly one cycle.
- R8: Ticks spent in pre-charge, constant current, constant voltage and top-off add up to one count. When that count reaches 600 minutes, the status becomes 110 with the one-cycle interrupt.
- R9: When top-off ends on the same tick that the 600-minute limit is reached, the result is complete (101) and no interrupt is raised.
- R10: A temperature outside the window during charging gives status 100, mode 00 and current target 00, and the safety count holds. When the temperature returns, charging resumes in pre-charge or constant current according to the full-rate flag.
- R11: Clearing enable in any state other than complete gives status 000 and zeroes the safety count. Losing both sources does the same from every state.
- R12: With no source, both LEDs are off. Red is on while a source is present, and blinks during error (100) and expiry (110). Green blinks during constant voltage, is steady on in top-off and complete, and is off otherwise. A blink starts with its on phase, and each phase lasts BLINK_HALF ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| chg_en_i | input | 1 | Charge enable |
| adp_present_i | input | 1 | Adapter supply detected |
| usb_present_i | input | 1 | USB supply detected |
| bat_below_full_i | input | 1 | Battery under full-rate threshold |
| bat_at_term_i | input | 1 | Battery at termination voltage |
| cur_below_eoc_i | input | 1 | Charge current under end-of-charge level |
| bat_below_restart_i | input | 1 | Battery under restart level |
| temp_in_window_i | input | 1 | Battery temperature inside window |
| vterm_sel_i | input | 2 | Termination code: 00 4.1 V, 01 4.2 V, 10 4.38 V |
| eoc_sel_i | input | 1 | End-of-charge level: 0 for 5%, 1 for 10% |
| mode_o | output | 2 | Regulation mode: 00 idle, 01 pre-charge, 10 CC, 11 CV |
| cur_sel_o | output | 2 | Current target code |
| status_o | output | 3 | Phase status code |
| rst_lvl_o | output | 2 | Restart comparator threshold code |
| eoc_ref_o | output | 2 | End-of-charge comparator reference code |
| tmr_irq_o | output | 1 | Safety-timer expiry pulse |
| led_red_o | output | 1 | Red LED drive |
| led_green_o | output | 1 | Green LED drive |

## Verification
The end of the top-off period and the 600-minute safety limit can fall on the same tick. The bench provokes this by spending exactly 600 minus 21 minutes of ticks in constant current, moving through constant voltage with no ticks, and then feeding the 21 minutes of top-off. It then expects status 101 with the interrupt low, which tells the completion-first ordering apart from both an expiry-first ordering and a count that is off by one.

// File: rtl/lichg_pkg.sv
package lichg_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'b000,
        ST_PREQ    = 3'b001,
        ST_CC      = 3'b010,
        ST_CV      = 3'b011,
        ST_FAULT   = 3'b100,
        ST_DONE    = 3'b101,
        ST_EXPIRED = 3'b110,
        ST_TOPOFF  = 3'b111
    } chg_state_e;

    typedef enum logic [1:0] {
        MD_IDLE = 2'b00,
        MD_PREQ = 2'b01,
        MD_CC   = 2'b10,
        MD_CV   = 2'b11
    } chg_mode_e;

    typedef enum logic [1:0] {
        CS_NONE     = 2'b00,
        CS_PREQ_PCT = 2'b01,
        CS_PREQ_USB = 2'b10,
        CS_FULL     = 2'b11
    } cur_sel_e;

    typedef struct packed {
        chg_state_e st;
        logic       src;
        logic       adp;
        logic       irq;
    } seq_regs_t;

    function automatic logic is_charging(chg_state_e s);
        return (s == ST_PREQ) || (s == ST_CC) || (s == ST_CV) || (s == ST_TOPOFF);
    endfunction

endpackage

// File: rtl/lichg_timer.sv
module lichg_timer #(
    parameter int PREQ_T = 3600000,
    parameter int TOT_T  = 36000000,
    parameter int TOP_T  = 1260000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic preq_i,
    input  logic clr_i,
    input  logic top_run_i,
    output logic exp_o,
    output logic top_end_o
);
    localparam int CW = $clog2(TOT_T + 1);
    localparam int TW = $clog2(TOP_T + 1);
    localparam logic [CW-1:0] PREQ_LAST = CW'(PREQ_T - 1);
    localparam logic [CW-1:0] TOT_LAST  = CW'(TOT_T - 1);
    localparam logic [TW-1:0] TOP_LAST  = TW'(TOP_T - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [TW-1:0] top;
    } tmr_regs_t;

    tmr_regs_t r_q, r_d;

    assign exp_o     = run_i && tick_i && (r_q.cnt >= (preq_i ? PREQ_LAST : TOT_LAST));
    assign top_end_o = top_run_i && tick_i && (r_q.top >= TOP_LAST);

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.cnt = '0;
        end else if (run_i && tick_i) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        if (!top_run_i || top_end_o) begin
            r_d.top = '0;
        end else if (tick_i) begin
            r_d.top = r_q.top + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CW'(TOT_T));  // R8
    AST_TOP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.top <= TOP_LAST);  // R5

endmodule

// File: rtl/lichg_blink.sv
module lichg_blink #(
    parameter int BLINK_HALF = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic req_i,
    output logic phase_o
);
    localparam int HW = $clog2(BLINK_HALF + 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(BLINK_HALF - 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          ph;
    } blk_regs_t;

    blk_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!req_i) begin
            r_d.cnt = '0;
            r_d.ph  = 1'b1;
        end else if (tick_i) begin
            if (r_q.cnt >= HALF_LAST) begin
                r_d.cnt = '0;
                r_d.ph  = ~r_q.ph;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cnt: '0, ph: 1'b1};
        else        r_q <= r_d;
    end

    assign phase_o = r_q.ph;

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !tick_i) |=> (r_q.ph == $past(r_q.ph)));  // R12

endmodule

// File: rtl/lichg_seq.sv
module lichg_seq
    import lichg_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60000,
    parameter int BLINK_HALF    = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms_i,
    input  logic       chg_en_i,
    input  logic       adp_present_i,
    input  logic       usb_present_i,
    input  logic       bat_below_full_i,
    input  logic       bat_at_term_i,
    input  logic       cur_below_eoc_i,
    input  logic       bat_below_restart_i,
    input  logic       temp_in_window_i,
    input  logic [1:0] vterm_sel_i,
    input  logic       eoc_sel_i,
    output logic [1:0] mode_o,
    output logic [1:0] cur_sel_o,
    output logic [2:0] status_o,
    output logic [1:0] rst_lvl_o,
    output logic [1:0] eoc_ref_o,
    output logic       tmr_irq_o,
    output logic       led_red_o,
    output logic       led_green_o
);
    localparam int PREQ_T = 60 * TICKS_PER_MIN;
    localparam int TOT_T  = 600 * TICKS_PER_MIN;
    localparam int TOP_T  = 21 * TICKS_PER_MIN;

    seq_regs_t r_q, r_d;
    logic      tmr_exp, top_end, restart, blink_ph, blink_req;
    logic      any_src;

    assign any_src = adp_present_i | usb_present_i;

    always_comb begin
        r_d     = r_q;
        r_d.src = any_src;
        r_d.adp = adp_present_i;
        r_d.irq = 1'b0;
        restart = 1'b0;
        if (!any_src) begin
            r_d.st = ST_OFF;
        end else begin
            case (r_q.st)
                ST_OFF: begin
                    if (chg_en_i)
                        r_d.st = !temp_in_window_i ? ST_FAULT :
                                 (bat_below_full_i ? ST_PREQ : ST_CC);
                end
                ST_FAULT: begin
                    if (!chg_en_i)
                        r_d.st = ST_OFF;
                    else if (temp_in_window_i)
                        r_d.st = bat_below_full_i ? ST_PREQ : ST_CC;
                end
                ST_EXPIRED: begin
                    if (!chg_en_i) r_d.st = ST_OFF;
                end
                ST_DONE: begin
                    if (chg_en_i && bat_below_restart_i) begin
                        r_d.st  = ST_CC;
                        restart = 1'b1;
                    end
                end
                default: begin
                    if (!chg_en_i) begin
                        r_d.st = ST_OFF;
                    end else if (!temp_in_window_i) begin
                        r_d.st = ST_FAULT;
                    end else if (top_end) begin
                        r_d.st = ST_DONE;
                    end else if (tmr_exp) begin
                        r_d.st  = ST_EXPIRED;
                        r_d.irq = 1'b1;
                    end else begin
                        case (r_q.st)
                            ST_PREQ: if (!bat_below_full_i) r_d.st = ST_CC;
                            ST_CC:   if (bat_at_term_i)     r_d.st = ST_CV;
                            ST_CV:   if (cur_below_eoc_i)   r_d.st = ST_TOPOFF;
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_OFF, src: 1'b0, adp: 1'b0, irq: 1'b0};
        else        r_q <= r_d;
    end

    lichg_timer #(
        .PREQ_T (PREQ_T),
        .TOT_T  (TOT_T),
        .TOP_T  (TOP_T)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_ms_i),
        .run_i     (is_charging(r_q.st)),
        .preq_i    (r_q.st == ST_PREQ),
        .clr_i     ((r_q.st == ST_OFF) || restart),
        .top_run_i (r_q.st == ST_TOPOFF),
        .exp_o     (tmr_exp),
        .top_end_o (top_end)
    );

    assign blink_req = (r_q.st == ST_CV) || (r_q.st == ST_FAULT) || (r_q.st == ST_EXPIRED);

    lichg_blink #(
        .BLINK_HALF (BLINK_HALF)
    ) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_ms_i),
        .req_i   (blink_req),
        .phase_o (blink_ph)
    );

    always_comb begin
        case (r_q.st)
            ST_PREQ:             mode_o = MD_PREQ;
            ST_CC:               mode_o = MD_CC;
            ST_CV, ST_TOPOFF:    mode_o = MD_CV;
            default:             mode_o = MD_IDLE;
        endcase
        case (r_q.st)
            ST_PREQ:                cur_sel_o = r_q.adp ? CS_PREQ_PCT : CS_PREQ_USB;
            ST_CC, ST_CV, ST_TOPOFF: cur_sel_o = CS_FULL;
            default:                cur_sel_o = CS_NONE;
        endcase
        rst_lvl_o   = (vterm_sel_i == 2'b11) ? 2'b00 : vterm_sel_i;
        eoc_ref_o   = (r_q.st == ST_CV) ? (eoc_sel_i ? 2'b10 : 2'b01) : 2'b00;
        led_red_o   = r_q.src && (((r_q.st == ST_FAULT) || (r_q.st == ST_EXPIRED)) ? blink_ph : 1'b1);
        led_green_o = r_q.src && ((r_q.st == ST_CV) ? blink_ph :
                                  ((r_q.st == ST_TOPOFF) || (r_q.st == ST_DONE)));
    end

    assign status_o  = r_q.st;
    assign tmr_irq_o = r_q.irq;

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.irq |=> !r_q.irq);  // R7
    AST_IRQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.irq |-> (r_q.st == ST_EXPIRED));  // R8
    AST_NOSRC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.src |-> (r_q.st == ST_OFF));  // R11
    AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_DONE) && ($past(r_q.st) != ST_DONE)) |-> ($past(r_q.st) == ST_TOPOFF));  // R5

endmodule

// File: tb/lichg_seq_test.sv
module lichg_seq_test;
    localparam int TPM    = 10;
    localparam int HALF   = 5;
    localparam int PREQ_T = 60 * TPM;
    localparam int TOT_T  = 600 * TPM;
    localparam int TOP_T  = 21 * TPM;

    localparam int F_STAT = 0, F_MODE = 1, F_CUR = 2, F_RED = 3,
                   F_GRN = 4, F_IRQ = 5, F_RLVL = 6, F_EREF = 7;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic       en = 0, adp = 0, usb = 0, low = 0, term = 0, eoc = 0, rstf = 0, temp = 0;
    logic [1:0] vterm = 2'b00;
    logic       eoc_sel = 1'b0;
    logic [1:0] mode, cur, rlvl, eref;
    logic [2:0] status;
    logic       irq, red, grn;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct {
        int    fld;
        int    exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    lichg_seq #(.TICKS_PER_MIN(TPM), .BLINK_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .tick_ms_i(tick), .chg_en_i(en),
        .adp_present_i(adp), .usb_present_i(usb), .bat_below_full_i(low),
        .bat_at_term_i(term), .cur_below_eoc_i(eoc), .bat_below_restart_i(rstf),
        .temp_in_window_i(temp), .vterm_sel_i(vterm), .eoc_sel_i(eoc_sel),
        .mode_o(mode), .cur_sel_o(cur), .status_o(status), .rst_lvl_o(rlvl),
        .eoc_ref_o(eref), .tmr_irq_o(irq), .led_red_o(red), .led_green_o(grn)
    );

    function automatic int actual(int f);
        case (f)
            F_STAT:  return int'(status);
            F_MODE:  return int'(mode);
            F_CUR:   return int'(cur);
            F_RED:   return int'(red);
            F_GRN:   return int'(grn);
            F_IRQ:   return int'(irq);
            F_RLVL:  return int'(rlvl);
            default: return int'(eref);
        endcase
    endfunction

    // monitor: pops every expectation pushed since the last falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (actual(it.fld) != it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %0d expected %0d", it.tag, actual(it.fld), it.exp);
            end
        end
    end

    task automatic expect_v(input int f, input int v, input string tag);
        item_t it;
        it.fld = f; it.exp = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic sync();
        @(negedge clk); #1;
    endtask

    task automatic go(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic ticks(input int n);
        sync();
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic restart_en();
        sync(); en = 0; go(1);
        sync(); en = 1; go(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        go(3);
        sync(); rst_n = 1; go(1);
        expect_v(F_STAT, 0, "R1 status"); expect_v(F_MODE, 0, "R1 mode");
        expect_v(F_CUR, 0, "R1 cur");     expect_v(F_RED, 0, "R1 red");
        expect_v(F_GRN, 0, "R1 green");   expect_v(F_IRQ, 0, "R1 irq");

        // source present, enable low
        sync(); adp = 1; temp = 1; go(1);
        expect_v(F_STAT, 0, "R12 status off"); expect_v(F_RED, 1, "R12 red on with source");
        expect_v(F_GRN, 0, "R12 green off");

        // pre-charge and its current choices
        sync(); en = 1; low = 1; go(1);
        expect_v(F_STAT, 1, "R2 precharge"); expect_v(F_MODE, 1, "R2 mode");
        expect_v(F_CUR, 1, "R3 adapter pct");
        sync(); adp = 0; usb = 1; go(1);
        expect_v(F_CUR, 2, "R3 usb 50mA");
        sync(); adp = 1; go(1);
        expect_v(F_CUR, 1, "R3 adapter priority");
        sync(); low = 0; go(1);
        expect_v(F_STAT, 2, "R2 cc"); expect_v(F_MODE, 2, "R2 cc mode");
        expect_v(F_CUR, 3, "R3 full"); expect_v(F_EREF, 0, "R4 eoc ref off in cc");

        // restart level mapping
        sync(); vterm = 2'b01; go(1); expect_v(F_RLVL, 1, "R6 rst 4.0");
        sync(); vterm = 2'b10; go(1); expect_v(F_RLVL, 2, "R6 rst 4.2");
        sync(); vterm = 2'b11; go(1); expect_v(F_RLVL, 0, "R6 rst reserved");
        sync(); vterm = 2'b00; go(1); expect_v(F_RLVL, 0, "R6 rst 3.9");

        // constant voltage with blink
        sync(); term = 1; eoc_sel = 1; go(1);
        expect_v(F_STAT, 3, "R4 cv"); expect_v(F_MODE, 3, "R4 cv mode");
        expect_v(F_EREF, 2, "R4 eoc 10pct"); expect_v(F_GRN, 1, "R12 green blink on");
        sync(); eoc_sel = 0; go(1);
        expect_v(F_EREF, 1, "R4 eoc 5pct");
        ticks(HALF - 1); expect_v(F_GRN, 1, "R12 green still on");
        ticks(1);        expect_v(F_GRN, 0, "R12 green off phase");
        ticks(HALF);     expect_v(F_GRN, 1, "R12 green on again");

        // top-off and completion (safety count is 2*HALF here)
        sync(); eoc = 1; go(1);
        expect_v(F_STAT, 7, "R4 topoff"); expect_v(F_MODE, 3, "R4 topoff mode");
        expect_v(F_GRN, 1, "R12 green steady"); expect_v(F_EREF, 0, "R4 eoc ref off");
        ticks(TOP_T - 1); expect_v(F_STAT, 7, "R5 topoff not yet done");
        ticks(1);
        expect_v(F_STAT, 5, "R5 complete"); expect_v(F_MODE, 0, "R5 mode idle");
        expect_v(F_CUR, 0, "R5 no current"); expect_v(F_GRN, 1, "R12 green done");
        sync(); en = 0; go(2);
        expect_v(F_STAT, 5, "R5 enable ignored");

        // restart from complete, then full-window expiry
        sync(); en = 1; rstf = 1; term = 0; eoc = 0; go(1);
        expect_v(F_STAT, 2, "R6 restart cc");
        sync(); rstf = 0;
        ticks(TOT_T - 1); expect_v(F_STAT, 2, "R6 count restarted");
        ticks(1);
        expect_v(F_STAT, 6, "R8 expired"); expect_v(F_IRQ, 1, "R8 irq");
        expect_v(F_GRN, 0, "R12 green off expired"); expect_v(F_RED, 1, "R12 red blink on");
        go(1); expect_v(F_IRQ, 0, "R7 irq one cycle");
        ticks(HALF); expect_v(F_RED, 0, "R12 red blink off");
        sync(); en = 0; go(1);
        expect_v(F_STAT, 0, "R11 enable cleared");

        // pre-charge limit
        sync(); en = 1; low = 1; go(1);
        expect_v(F_STAT, 1, "R7 precharge");
        ticks(PREQ_T - 1); expect_v(F_STAT, 1, "R7 before limit");
        ticks(1);
        expect_v(F_STAT, 6, "R7 precharge expired"); expect_v(F_IRQ, 1, "R7 irq");

        // pre-charge time counts toward the overall limit
        restart_en();
        expect_v(F_STAT, 1, "R8 precharge again");
        ticks(PREQ_T - 1);
        sync(); low = 0; go(1);
        expect_v(F_STAT, 2, "R8 cc after precharge");
        ticks(TOT_T - PREQ_T); expect_v(F_STAT, 2, "R8 before total");
        ticks(1); expect_v(F_STAT, 6, "R8 total includes precharge");

        // temperature fault holds the count
        restart_en();
        expect_v(F_STAT, 2, "R10 cc");
        ticks(100);
        sync(); temp = 0; go(1);
        expect_v(F_STAT, 4, "R10 fault"); expect_v(F_MODE, 0, "R10 mode");
        expect_v(F_CUR, 0, "R10 cur"); expect_v(F_GRN, 0, "R12 green fault");
        expect_v(F_RED, 1, "R12 red fault on");
        ticks(HALF); expect_v(F_RED, 0, "R12 red fault off");
        ticks(1000);
        sync(); temp = 1; go(1);
        expect_v(F_STAT, 2, "R10 resume cc");
        ticks(TOT_T - 101); expect_v(F_STAT, 2, "R10 held count");
        ticks(1); expect_v(F_STAT, 6, "R10 expiry after hold");

        // loss of source clears the count
        restart_en();
        ticks(3000);
        sync(); adp = 0; usb = 0; go(1);
        expect_v(F_STAT, 0, "R11 source lost"); expect_v(F_RED, 0, "R12 red no source");
        expect_v(F_GRN, 0, "R12 green no source");
        sync(); adp = 1; go(1);
        expect_v(F_STAT, 2, "R11 back to cc");
        ticks(TOT_T - 1); expect_v(F_STAT, 2, "R11 count cleared");
        ticks(1); expect_v(F_STAT, 6, "R11 expiry after clear");

        // top-off end coincides with overall limit
        restart_en();
        ticks(TOT_T - TOP_T);
        sync(); term = 1; go(1);
        sync(); eoc = 1; go(1);
        expect_v(F_STAT, 7, "R9 topoff");
        ticks(TOP_T - 1); expect_v(F_STAT, 7, "R9 topoff running");
        ticks(1);
        expect_v(F_STAT, 5, "R9 complete wins"); expect_v(F_IRQ, 0, "R9 no irq");

        sync(); sync();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule